// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is the timing generator of a self-scanning photodiode line sensor. It watches a slow sensor clock input and an integration pulse input, both sampled by a fast system clock. From them it places every readout event on a half-clock grid: the per-channel video-valid window, the channel index, the sample strobe, the active-low end-of-scan pulse and the integration-active flag. Analog charge amplifiers, clamping, holding and gain selection are out of scope. Video is represented only by a valid flag, and the flag being low stands for the high-impedance state.

Positions are counted in half sensor clocks. The falling edge of sensor clock k sits at half-position 2k, and the rising edge that follows it sits at 2k+1. In master mode a scan is armed by the falling edge of the integration pulse, and the next sensor clock falling edge is clock 1. In slave mode the falling edge of the external start input arms the scan instead; in a cascade that input is wired to the upstream sensor's end-of-scan output. Sensors can be chained this way.

The scan controller has five states:
- `ST_IDLE`: no scan is running.
- `ST_ARMED`: waiting for the first sensor clock fall.
- `ST_LEAD`: counting half-positions up to the first window.
- `ST_READ`: stepping channels with an eight-phase counter.
- `ST_EOS`: end-of-scan pulse.

The transitions are:
- start → `ST_ARMED`, from any state.
- first fall → `ST_LEAD`.
- lead done → `ST_READ`.
- last window closed → `ST_EOS`.
- pulse done → `ST_IDLE`.

Top module: `lss_readout_seq`

## Requirements
- R1: After system reset the outputs are as follows, and they stay so with the sensor clock running and no start: `video_valid`=0, `trig`=0, `eos_n`=1, `integrating`=0, `chan_idx`=0.
- R2: In master mode, the first sensor clock fall after `integ_pulse` falls is clock 1 (half-position 2). Channel 0 video is valid from half-position 37 (18.5 clocks) up to, but not including, half-position 41 (20.5 clocks).
- R3: Channel c (0-based) is valid for half-positions 37+8c to 40+8c, which is two clocks at a four-clock pitch. `chan_idx` equals c throughout that window and changes only when a new window opens.
- R4: `trig` is high for one sensor clock, at half-positions 39+8c and 40+8c. It therefore rises at 19.5 clocks plus 4 clocks per channel, and it is high only inside a valid window.
- R5: `eos_n` is low for one sensor clock, at half-positions 41+8(N_CH-1) and 42+8(N_CH-1). After that, `video_valid` stays low until the next scan.
- R6: `integrating` becomes 1 at the 8th sensor clock fall after an `integ_pulse` rise, if the pulse is still high. It becomes 0 at the 8th fall after an `integ_pulse` fall, if the pulse is still low. Any new pulse edge restarts that count.
- R7: In slave mode (`slave_mode`=1), a fall of `ext_start_n` arms the scan with the same timing as R2 to R5. Falls of `integ_pulse` do not start a scan.
- R8: In master mode, an `integ_pulse` fall that arrives during a scan abandons that scan and restarts the timing of R2 from the next clock fall.
- R9: In master mode, falls of `ext_start_n` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the sensor clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| sensor_clk | input | 1 | Sensor clock; both of its edges form the half-clock grid |
| integ_pulse | input | 1 | Integration/reset pulse, changing with sensor clock rises |
| ext_start_n | input | 1 | Active-low external start, taken from the upstream end-of-scan |
| slave_mode | input | 1 | 1 = start from `ext_start_n`, 0 = start from `integ_pulse` |
| trig | output | 1 | Per-channel sample strobe |
| chan_idx | output | $clog2(N_CH) | Index of the channel in the current window |
| video_valid | output | 1 | 1 while channel video is valid; 0 stands for high impedance |
| eos_n | output | 1 | Active-low end-of-scan pulse |
| integrating | output | 1 | Charge integration is active |

## Verification
The hardest situation to reach is a restart in the middle of a scan. It needs a pulse edge placed on a sensor clock rise deep inside the channel stepping, and the scan must then be followed back from half-position 2. The stimulus is driven one half-clock at a time, so any edge can be placed on any chosen half-position. A reference model of half-positions and clock-fall counts gives the expected value of every output after every half-clock. The bench uses a small channel count, so each scan is swept completely and every window, strobe and end-of-scan slot is compared. This includes a mid-scan restart and a slave start after ignored pulse edges.

// File: rtl/lss_pkg.sv
package lss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LEAD,
        ST_READ,
        ST_EOS
    } scan_state_t;

    // Half-clock grid: fall of clock k is position 2k, following rise is 2k+1
    localparam int START_POS  = 2;   // clock 1 fall
    localparam int FIRST_OPEN = 37;  // 18.5 clocks
    localparam int LEAD_LAST  = FIRST_OPEN - 1;
    localparam int PHASES     = 8;   // 4-clock channel pitch
    localparam int VALID_PH   = 4;   // 2 clocks valid
    localparam int TRIG_PH    = 2;   // strobe starts 1 clock into window
    localparam int EOS_HALVES = 2;   // one sensor clock low
endpackage

// File: rtl/lss_edge_sense.sv
module lss_edge_sense #(
    parameter int            W        = 3,
    parameter logic [W-1:0]  IDLE_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stage0;
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage0 <= IDLE_LVL;
            stage1 <= IDLE_LVL;
        end else begin
            stage0 <= raw;
            stage1 <= stage0;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise[b] =  stage0[b] & ~stage1[b];
        assign fall[b] = ~stage0[b] &  stage1[b];
    end

    assign level = stage0;
endmodule

// File: rtl/lss_integ_track.sv
module lss_integ_track #(
    parameter int DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_fall,
    input  logic pulse_rise,
    input  logic pulse_fall,
    input  logic pulse_level,
    output logic integrating
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] fall_cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_cnt    <= '0;
            armed       <= 1'b0;
            integrating <= 1'b0;
        end else if (pulse_rise || pulse_fall) begin
            fall_cnt <= '0;
            armed    <= 1'b1;
        end else if (clk_fall && armed) begin
            if (fall_cnt == CW'(DELAY - 1)) begin
                integrating <= pulse_level;
                armed       <= 1'b0;
            end
            fall_cnt <= fall_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lss_scan_fsm.sv
module lss_scan_fsm
    import lss_pkg::*;
#(
    parameter int N_CH = 64,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_req,
    input  logic           clk_fall,
    input  logic           half_tick,
    output logic           trig,
    output logic           video_valid,
    output logic           eos_n,
    output logic [CHW-1:0] chan_idx
);
    localparam int PW  = $clog2(FIRST_OPEN + 1);
    localparam int PHW = $clog2(PHASES);
    localparam int EW  = $clog2(EOS_HALVES + 1);

    scan_state_t    state, state_nx;
    logic [PW-1:0]  pos;
    logic [PHW-1:0] phase;
    logic [CHW-1:0] chan;
    logic [EW-1:0]  eos_cnt;

    logic lead_done, last_closed, eos_done;
    assign lead_done   = half_tick && (pos == PW'(LEAD_LAST));
    assign last_closed = half_tick && (phase == PHW'(VALID_PH - 1))
                         && (chan == CHW'(N_CH - 1));
    assign eos_done    = half_tick && (eos_cnt == EW'(EOS_HALVES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (start_req) begin
            state_nx = ST_ARMED;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARMED: if (clk_fall)    state_nx = ST_LEAD;
                ST_LEAD:  if (lead_done)   state_nx = ST_READ;
                ST_READ:  if (last_closed) state_nx = ST_EOS;
                ST_EOS:   if (eos_done)    state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // position, phase and channel counters
    always_ff @(posedge clk) begin
        if (!rst_n || start_req) begin
            pos     <= '0;
            phase   <= '0;
            chan    <= '0;
            eos_cnt <= '0;
        end else begin
            unique case (state)
                ST_ARMED: if (clk_fall) pos <= PW'(START_POS);
                ST_LEAD: if (half_tick) begin
                    pos   <= pos + 1'b1;
                    phase <= '0;
                    chan  <= '0;
                end
                ST_READ: if (half_tick) begin
                    phase <= phase + 1'b1;
                    if (phase == PHW'(PHASES - 1)) chan <= chan + 1'b1;
                    eos_cnt <= '0;
                end
                ST_EOS: if (half_tick) eos_cnt <= eos_cnt + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        video_valid = 1'b0;
        trig        = 1'b0;
        eos_n       = 1'b1;
        unique case (state)
            ST_READ: begin
                video_valid = (phase < PHW'(VALID_PH));
                trig        = (phase >= PHW'(TRIG_PH)) && (phase < PHW'(VALID_PH));
            end
            ST_EOS:  eos_n = 1'b0;
            default: ;
        endcase
    end

    assign chan_idx = chan;
endmodule

// File: rtl/lss_readout_seq.sv
module lss_readout_seq #(
    parameter int N_CH        = 64,
    parameter int INTEG_DELAY = 8,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sensor_clk,
    input  logic           integ_pulse,
    input  logic           ext_start_n,
    input  logic           slave_mode,
    output logic           trig,
    output logic [CHW-1:0] chan_idx,
    output logic           video_valid,
    output logic           eos_n,
    output logic           integrating
);
    localparam int           NIN      = 3;
    localparam int           B_SCLK   = 0;
    localparam int           B_PULSE  = 1;
    localparam int           B_XSTART = 2;
    localparam logic [NIN-1:0] IDLE_LVL = 3'b101;

    logic [NIN-1:0] lvl, rise, fall;
    logic           start_req;

    lss_edge_sense #(.W(NIN), .IDLE_LVL(IDLE_LVL)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({ext_start_n, integ_pulse, sensor_clk}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    assign start_req = slave_mode ? fall[B_XSTART] : fall[B_PULSE];

    lss_integ_track #(.DELAY(INTEG_DELAY)) u_integ (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_fall    (fall[B_SCLK]),
        .pulse_rise  (rise[B_PULSE]),
        .pulse_fall  (fall[B_PULSE]),
        .pulse_level (lvl[B_PULSE]),
        .integrating (integrating)
    );

    lss_scan_fsm #(.N_CH(N_CH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .clk_fall    (fall[B_SCLK]),
        .half_tick   (rise[B_SCLK] | fall[B_SCLK]),
        .trig        (trig),
        .video_valid (video_valid),
        .eos_n       (eos_n),
        .chan_idx    (chan_idx)
    );
endmodule

// File: rtl/lss_readout_seq_chk.sv
module lss_readout_seq_chk #(
    parameter int N_CH = 64,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           trig,
    input logic [CHW-1:0] chan_idx,
    input logic           video_valid,
    input logic           eos_n
);
    a_r4_trig_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> video_valid);

    a_r4_trig_after_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(video_valid));

    a_r5_eos_blanks_video: assert property (@(posedge clk) disable iff (!rst_n)
        !eos_n |-> !video_valid);

    a_r5_eos_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eos_n) |-> (int'($past(chan_idx)) == N_CH - 1));

    a_r3_chan_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (video_valid && $past(video_valid)) |-> $stable(chan_idx));

    a_r3_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(video_valid) |-> (chan_idx == '0 || chan_idx == CHW'($past(chan_idx) + 1'b1)));
endmodule

bind lss_readout_seq lss_readout_seq_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .chan_idx    (chan_idx),
    .video_valid (video_valid),
    .eos_n       (eos_n)
);

// File: tb/test_lss_readout_seq.sv
module test_lss_readout_seq;
    localparam int N   = 8;
    localparam int CHW = $clog2(N);
    localparam int SCAN_HALVES = 44 + 8 * (N - 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b1, pulse = 1'b0, xs_n = 1'b1, slave = 1'b0;
    logic trig, video_valid, eos_n, integrating;
    logic [CHW-1:0] chan_idx;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int  p = 0, falls = 0;
    bit  active = 0, pending = 0, exp_integ = 0;
    string cur_req = "R1";

    always #4 clk = ~clk; // 125 MHz

    lss_readout_seq #(.N_CH(N)) i_lss_readout_seq (
        .clk(clk), .rst_n(rst_n), .sensor_clk(sclk), .integ_pulse(pulse),
        .ext_start_n(xs_n), .slave_mode(slave), .trig(trig), .chan_idx(chan_idx),
        .video_valid(video_valid), .eos_n(eos_n), .integrating(integrating)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] half=%0d actual=%0d expected=%0d", req, cur_req, p, act, exp);
        end
    endtask

    task automatic compare();
        int  off;
        bit  e_valid, e_trig, e_eos;
        int  e_chan;
        off     = p - 37;
        e_valid = active && off >= 0 && (off / 8) < N && (off % 8) < 4;
        e_trig  = e_valid && (off % 8) >= 2;
        e_eos   = active && p >= 41 + 8 * (N - 1) && p <= 42 + 8 * (N - 1);
        e_chan  = (off >= 0) ? off / 8 : 0;
        chk((e_valid && off < 8) ? "R2 valid" : "R3 valid", video_valid, e_valid);
        chk("R4 trig", trig, e_trig);
        chk("R5 eos_n", eos_n, !e_eos);
        chk("R6 integrating", integrating, exp_integ);
        if (e_valid) chk("R3 chan_idx", chan_idx, e_chan);
    endtask

    // one half sensor clock, with optional input changes on a rise
    task automatic tick_with(input logic new_pulse, input logic new_xs);
        @(negedge clk);
        sclk = ~sclk;
        if (!sclk) begin
            falls++;
            if (falls == 8) exp_integ = pulse;
            if (pending) begin pending = 0; active = 1; p = 2; end
            else if (active) p++;
        end else if (active) p++;
        if (new_pulse != pulse) begin
            falls = 0;
            if (!new_pulse && !slave) begin pending = 1; active = 0; end
            pulse = new_pulse;
        end
        if (!new_xs && xs_n && slave) begin pending = 1; active = 0; end
        xs_n = new_xs;
        repeat (4) @(negedge clk);
        compare();
    endtask

    task automatic tick();
        tick_with(pulse, xs_n);
    endtask

    // change inputs on the next sensor clock rise
    task automatic at_rise(input logic new_pulse, input logic new_xs);
        if (sclk) tick();
        tick_with(new_pulse, new_xs);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state, clock running, no start
        cur_req = "R1";
        chk("R1 video_valid", video_valid, 0);
        chk("R1 trig", trig, 0);
        chk("R1 eos_n", eos_n, 1);
        chk("R1 integrating", integrating, 0);
        chk("R1 chan_idx", chan_idx, 0);
        ticks(30);

        // R2/R3/R4/R5/R6: master scan with 10-clock pulse
        cur_req = "R2";
        at_rise(1'b1, 1'b1);
        ticks(19);
        at_rise(1'b0, 1'b1);
        ticks(SCAN_HALVES + 10);

        // second master scan, longer pulse
        cur_req = "R6";
        at_rise(1'b1, 1'b1);
        ticks(25);
        at_rise(1'b0, 1'b1);
        ticks(SCAN_HALVES + 6);

        // R9: external start ignored in master mode
        cur_req = "R9";
        at_rise(1'b0, 1'b0);
        ticks(3);
        at_rise(1'b0, 1'b1);
        ticks(60);

        // R8: restart in the middle of a scan
        cur_req = "R8";
        at_rise(1'b1, 1'b1);
        ticks(19);
        at_rise(1'b0, 1'b1);
        ticks(58);
        at_rise(1'b1, 1'b1);
        ticks(3);
        at_rise(1'b0, 1'b1);
        ticks(SCAN_HALVES + 8);

        // R7: slave mode, pulse falls ignored, external start arms scan
        cur_req = "R7";
        slave = 1'b1;
        at_rise(1'b1, 1'b1);
        ticks(19);
        at_rise(1'b0, 1'b1);
        ticks(70);
        at_rise(1'b0, 1'b0);
        ticks(3);
        at_rise(1'b0, 1'b1);
        ticks(SCAN_HALVES + 6);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule